// File: doc/BRIEF.md
# Command Issue Handshake Unit

This unit sits between a register interface and the card-interface logic of a memory-card host controller. Software first loads a 32-bit argument, then writes a 32-bit command word with its start bit set. The unit holds the command, presents it to the card-interface side over a valid/ready pair, and clears the start bit by itself the moment that side takes the command. A second write that arrives while a command is still in flight is not queued. It is rejected, and a hardware-locked error bit is raised so that software knows it must retry.

A command word flagged as a clock update never reaches the card-interface side. It only copies the pending clock configuration into the active clock configuration and then releases the start bit. After a normal command is accepted, the unit waits for the response with an 8-bit cycle limit and, when the command carries data, waits for the end of the data phase with a 24-bit cycle limit. Each wait ends either with a completion status bit or with a timeout status bit. A self-clearing controller-reset bit drops any command in flight.

State machine: `ST_IDLE` (nothing pending), `ST_PEND` (start bit set, offering the command), `ST_CLKUPD` (one cycle, commit the clock settings), `ST_RESP` (waiting for the response), `ST_DATA` (waiting for the end of data). The transitions are:
- IDLE to PEND on a start write without the clock flag.
- IDLE to CLKUPD on a start write with the clock flag.
- CLKUPD to IDLE always.
- PEND to RESP on acceptance.
- RESP to DATA on a response when the data flag is set.
- RESP to IDLE on a response without the data flag, or on a response timeout.
- DATA to IDLE on the end of data or on a data timeout.
- Any state to IDLE while the controller-reset bit is set.

Command word fields: bits [5:0] hold the index, bit 6 is the data flag, bit 7 is the write direction, bit 8 is the wait-for-idle flag, bit 9 is the clock-update flag, bits [11:10] hold the card number and bit 31 is the start bit. Raw status bits: bit 0 is command done, bit 1 is data done, bit 2 is response timeout, bit 3 is data timeout and bit 4 is hardware-locked error.

Top module: `cmd_issue_unit`

## Requirements
- R1: A command-word write with bit 31 set while idle makes `start_bit` and `ciu_valid` 1 in the next cycle, with `ciu_cmd` equal to the written word and `ciu_arg` equal to the last argument written.
- R2: On the clock edge where `ciu_valid` and `ciu_ready` are both 1, the command is accepted, and `start_bit` and `ciu_valid` are 0 from then on.
- R3: A start write with bit 9 set never raises `ciu_valid`. `start_bit` is 1 for exactly one cycle, and when it falls `clk_cfg_active` equals `clk_cfg_pend`.
- R4: A command-word write with bit 31 set while not idle, or while the controller-reset bit is set, sets raw status bit 4 and leaves `ciu_cmd` unchanged.
- R5: With bit 8 set, `ciu_valid` stays 0 and `start_bit` stays 1 while `card_busy` is 1. Without bit 8, `card_busy` has no effect on `ciu_valid`.
- R6: After acceptance, a `resp_seen` pulse in response-wait cycle d (0-based) with d ≤ `resp_tmo` sets status bit 0 only. If no response arrives by cycle `resp_tmo`, the unit sets bits 0 and 2 and returns to idle without a data phase. A response in the expiring cycle counts as a response.
- R7: When bit 6 is set and the response arrived, a `data_seen` pulse in data-wait cycle e with e ≤ `data_tmo` sets status bit 1. Otherwise bit 3 is set at the end of cycle `data_tmo`.
- R8: Writing `sts_clr_we` clears the raw status bits selected by `sts_clr_mask`. A bit being set in the same cycle stays 1.
- R9: A `ctl_rst_we` pulse makes `ctl_rst_bit` 1 for exactly one cycle. Afterwards `start_bit` and `ciu_valid` are 0 and the raw status is unchanged.
- R10: Argument writes while not idle, or while the reset bit is set, are ignored, so `ciu_arg` keeps its value.
- R11: After reset, `start_bit`, `ciu_valid`, `ctl_rst_bit`, `raw_status` and `clk_cfg_active` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arg_we | input | 1 | Argument write strobe |
| arg_wdata | input | ARG_W | Argument write data |
| cmd_we | input | 1 | Command-word write strobe |
| cmd_wdata | input | 32 | Command-word write data |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr_mask | input | 5 | Status bits to clear |
| ctl_rst_we | input | 1 | Sets the self-clearing controller-reset bit |
| clk_cfg_pend | input | CLK_CFG_W | Pending clock configuration |
| resp_tmo | input | RESP_TMO_W | Response wait limit in cycles |
| data_tmo | input | DATA_TMO_W | Data wait limit in cycles |
| ciu_ready | input | 1 | Card-interface side takes the command |
| card_busy | input | 1 | Data-busy status from the card side |
| resp_seen | input | 1 | Response received pulse |
| data_seen | input | 1 | Data phase finished pulse |
| ciu_valid | output | 1 | Command offered to the card-interface side |
| ciu_cmd | output | 32 | Held command word |
| ciu_arg | output | ARG_W | Held argument |
| start_bit | output | 1 | Start bit as seen by software |
| ctl_rst_bit | output | 1 | Controller-reset bit as seen by software |
| clk_cfg_active | output | CLK_CFG_W | Committed clock configuration |
| raw_status | output | 5 | Raw interrupt status |

## Verification
Two pairs of functions can fall in the same cycle. The response pulse can arrive in the very cycle the response counter expires, and a status clear can coincide with a new locked-error event. The bench draws response and data delays at random on both sides of the limit, including the exact limit, and expects a completion without a timeout on a tie. A directed case writes a second command while one is pending and clears the locked-error bit in that same cycle, and expects the bit to stay set.

// File: rtl/cmdiss_pkg.sv
package cmdiss_pkg;
    localparam int CW_W       = 32;
    localparam int CW_START   = 31;
    localparam int CW_UPDCLK  = 9;
    localparam int CW_WAIT    = 8;
    localparam int CW_WRITE   = 7;
    localparam int CW_DATA    = 6;

    localparam int STS_W      = 5;
    localparam int STS_DONE   = 0;
    localparam int STS_DOVER  = 1;
    localparam int STS_RTO    = 2;
    localparam int STS_DTO    = 3;
    localparam int STS_HLE    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_CLKUPD,
        ST_RESP,
        ST_DATA
    } issue_state_e;
endpackage

// File: rtl/cmdiss_timer.sv
module cmdiss_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    assign expired = run && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!run)     cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + 1'b1;
    end

    // R6: the wait counter never wraps while a wait is running
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/cmdiss_status.sv
module cmdiss_status #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] raw
);
    logic [N-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw <= '0;
        else        raw <= (raw & ~clr_eff) | set_vec;
    end

    for (genvar b = 0; b < N; b++) begin : g_chk
        // R8: a set in the same cycle as a clear wins
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[b] |=> raw[b]);
    end
endmodule

// File: rtl/cmdiss_fsm.sv
module cmdiss_fsm
    import cmdiss_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_we,
    input  logic [CW_W-1:0] cmd_wdata,
    input  logic            ctl_rst,
    input  logic            ciu_ready,
    input  logic            card_busy,
    input  logic            resp_seen,
    input  logic            data_seen,
    input  logic            rto_hit,
    input  logic            dto_hit,
    output logic [CW_W-1:0] cmd_q,
    output logic            start_bit,
    output logic            ciu_valid,
    output logic            resp_run,
    output logic            data_run,
    output logic            commit_clk,
    output logic            idle,
    output logic [STS_W-1:0] sts_set
);
    issue_state_e    state_q, state_d;
    logic [CW_W-1:0] cmd_d;
    logic            lock_hit;

    assign lock_hit = cmd_we && cmd_wdata[CW_START] && ((state_q != ST_IDLE) || ctl_rst);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
        end else begin
            state_q <= state_d;
            cmd_q   <= cmd_d;
        end
    end

    // next state and status events
    always_comb begin
        state_d    = state_q;
        cmd_d      = cmd_q;
        sts_set    = '0;
        commit_clk = 1'b0;
        if (ctl_rst) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_we && cmd_wdata[CW_START]) begin
                        cmd_d   = cmd_wdata;
                        state_d = cmd_wdata[CW_UPDCLK] ? ST_CLKUPD : ST_PEND;
                    end
                end
                ST_PEND: begin
                    if (ciu_valid && ciu_ready) state_d = ST_RESP;
                end
                ST_CLKUPD: begin
                    commit_clk = 1'b1;
                    state_d    = ST_IDLE;
                end
                ST_RESP: begin
                    if (resp_seen) begin
                        sts_set[STS_DONE] = 1'b1;
                        state_d = cmd_q[CW_DATA] ? ST_DATA : ST_IDLE;
                    end else if (rto_hit) begin
                        sts_set[STS_DONE] = 1'b1;
                        sts_set[STS_RTO]  = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
                ST_DATA: begin
                    if (data_seen) begin
                        sts_set[STS_DOVER] = 1'b1;
                        state_d = ST_IDLE;
                    end else if (dto_hit) begin
                        sts_set[STS_DTO] = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
        if (lock_hit) sts_set[STS_HLE] = 1'b1;
    end

    // outputs
    always_comb begin
        start_bit = (state_q == ST_PEND) || (state_q == ST_CLKUPD);
        ciu_valid = (state_q == ST_PEND) && !ctl_rst &&
                    !(cmd_q[CW_WAIT] && card_busy);
        resp_run  = (state_q == ST_RESP);
        data_run  = (state_q == ST_DATA);
        idle      = (state_q == ST_IDLE);
    end

    // R2: acceptance clears the start bit
    p_accept_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ciu_valid && ciu_ready) |=> (!start_bit && !ciu_valid));
    // R3: a clock update command holds the start bit for one cycle only
    p_upd_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (start_bit && cmd_q[CW_UPDCLK]) |=> !start_bit);
    // R3: a clock update command is never offered to the card side
    p_upd_never_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ciu_valid |-> !cmd_q[CW_UPDCLK]);
    // R5: no offer while waiting for the card to go idle
    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ciu_valid |-> !(cmd_q[CW_WAIT] && card_busy));
endmodule

// File: rtl/cmd_issue_unit.sv
module cmd_issue_unit
    import cmdiss_pkg::*;
#(
    parameter int ARG_W      = 32,
    parameter int CLK_CFG_W  = 16,
    parameter int RESP_TMO_W = 8,
    parameter int DATA_TMO_W = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  arg_we,
    input  logic [ARG_W-1:0]      arg_wdata,
    input  logic                  cmd_we,
    input  logic [31:0]           cmd_wdata,
    input  logic                  sts_clr_we,
    input  logic [4:0]            sts_clr_mask,
    input  logic                  ctl_rst_we,
    input  logic [CLK_CFG_W-1:0]  clk_cfg_pend,
    input  logic [RESP_TMO_W-1:0] resp_tmo,
    input  logic [DATA_TMO_W-1:0] data_tmo,
    input  logic                  ciu_ready,
    input  logic                  card_busy,
    input  logic                  resp_seen,
    input  logic                  data_seen,
    output logic                  ciu_valid,
    output logic [31:0]           ciu_cmd,
    output logic [ARG_W-1:0]      ciu_arg,
    output logic                  start_bit,
    output logic                  ctl_rst_bit,
    output logic [CLK_CFG_W-1:0]  clk_cfg_active,
    output logic [4:0]            raw_status
);
    logic             resp_run, data_run, rto_hit, dto_hit;
    logic             commit_clk, idle;
    logic [STS_W-1:0] sts_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ciu_arg        <= '0;
            ctl_rst_bit    <= 1'b0;
            clk_cfg_active <= '0;
        end else begin
            if (arg_we && idle && !ctl_rst_bit) ciu_arg <= arg_wdata;
            if (ctl_rst_bit)     ctl_rst_bit <= 1'b0;
            else if (ctl_rst_we) ctl_rst_bit <= 1'b1;
            if (commit_clk) clk_cfg_active <= clk_cfg_pend;
        end
    end

    cmdiss_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_we     (cmd_we),
        .cmd_wdata  (cmd_wdata),
        .ctl_rst    (ctl_rst_bit),
        .ciu_ready  (ciu_ready),
        .card_busy  (card_busy),
        .resp_seen  (resp_seen),
        .data_seen  (data_seen),
        .rto_hit    (rto_hit),
        .dto_hit    (dto_hit),
        .cmd_q      (ciu_cmd),
        .start_bit  (start_bit),
        .ciu_valid  (ciu_valid),
        .resp_run   (resp_run),
        .data_run   (data_run),
        .commit_clk (commit_clk),
        .idle       (idle),
        .sts_set    (sts_set)
    );

    cmdiss_timer #(.W(RESP_TMO_W)) u_resp_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (resp_run && !ctl_rst_bit),
        .limit   (resp_tmo),
        .expired (rto_hit)
    );

    cmdiss_timer #(.W(DATA_TMO_W)) u_data_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (data_run && !ctl_rst_bit),
        .limit   (data_tmo),
        .expired (dto_hit)
    );

    cmdiss_status #(.N(STS_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (sts_set),
        .clr_we   (sts_clr_we),
        .clr_mask (sts_clr_mask),
        .raw      (raw_status)
    );

    // R4: a premature start write flags the lock error and is dropped
    p_lock_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[CW_START] && (!idle || ctl_rst_bit))
        |=> (raw_status[STS_HLE] && ciu_cmd == $past(ciu_cmd)));
    // R9: the controller-reset bit clears itself and drops the command
    p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_bit |=> (!ctl_rst_bit && !start_bit));
    // R10: argument is frozen while busy
    p_arg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle || ctl_rst_bit) |=> $stable(ciu_arg));
endmodule

// File: tb/tb_cmd_issue_unit.sv
module tb_cmd_issue_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arg_we = 0, cmd_we = 0, sts_clr_we = 0, ctl_rst_we = 0;
    logic [31:0] arg_wdata = 0, cmd_wdata = 0;
    logic [4:0]  sts_clr_mask = 0;
    logic [15:0] clk_cfg_pend = 0;
    logic [7:0]  resp_tmo = 0;
    logic [23:0] data_tmo = 0;
    logic        ciu_ready = 0, card_busy = 0, resp_seen = 0, data_seen = 0;
    logic        ciu_valid, start_bit, ctl_rst_bit;
    logic [31:0] ciu_cmd, ciu_arg;
    logic [15:0] clk_cfg_active;
    logic [4:0]  raw_status;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    cmd_issue_unit dut (
        .clk(clk), .rst_n(rst_n), .arg_we(arg_we), .arg_wdata(arg_wdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .sts_clr_we(sts_clr_we),
        .sts_clr_mask(sts_clr_mask), .ctl_rst_we(ctl_rst_we),
        .clk_cfg_pend(clk_cfg_pend), .resp_tmo(resp_tmo), .data_tmo(data_tmo),
        .ciu_ready(ciu_ready), .card_busy(card_busy), .resp_seen(resp_seen),
        .data_seen(data_seen), .ciu_valid(ciu_valid), .ciu_cmd(ciu_cmd),
        .ciu_arg(ciu_arg), .start_bit(start_bit), .ctl_rst_bit(ctl_rst_bit),
        .clk_cfg_active(clk_cfg_active), .raw_status(raw_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected raw status after one command (R6, R7)
    function automatic logic [4:0] exp_sts(input bit has_data, input int d, input int l,
                                           input int e, input int m);
        logic [4:0] s = 5'b00001;
        if (d > l) s[2] = 1'b1;
        else if (has_data) begin
            if (e <= m) s[1] = 1'b1;
            else        s[3] = 1'b1;
        end
        return s;
    endfunction

    task automatic issue(input logic [31:0] w, input logic [31:0] a);
        arg_we = 1; arg_wdata = a;
        @(negedge clk);
        arg_we = 0; cmd_we = 1; cmd_wdata = w;
        @(negedge clk);
        cmd_we = 0;
    endtask

    task automatic clear_all();
        sts_clr_we = 1; sts_clr_mask = 5'h1f;
        @(negedge clk);
        sts_clr_we = 0;
    endtask

    task automatic run_cmd(input logic [31:0] w, input logic [31:0] a,
                           input int rd, input int d, input int e);
        int l = int'(resp_tmo);
        int m = int'(data_tmo);
        issue(w, a);
        chk("R1 valid", {31'd0, ciu_valid}, 32'd1);
        chk("R1 cmd", ciu_cmd, w);
        chk("R1 arg", ciu_arg, a);
        repeat (rd) @(negedge clk);
        ciu_ready = 1;
        @(negedge clk);
        ciu_ready = 0;
        chk("R2 start cleared", {31'd0, start_bit}, 32'd0);
        for (int k = 0; ; k++) begin
            resp_seen = (k == d);
            if (k == d || k == l) break;
            @(negedge clk);
        end
        @(negedge clk);
        resp_seen = 0;
        if (w[6] && d <= l) begin
            for (int j = 0; ; j++) begin
                data_seen = (j == e);
                if (j == e || j == m) break;
                @(negedge clk);
            end
            @(negedge clk);
            data_seen = 0;
        end
        chk("R6/R7 status", {27'd0, raw_status}, {27'd0, exp_sts(w[6], d, l, e, m)});
        clear_all();
        chk("R8 cleared", {27'd0, raw_status}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 start", {31'd0, start_bit}, 0);
        chk("R11 valid", {31'd0, ciu_valid}, 0);
        chk("R11 rstbit", {31'd0, ctl_rst_bit}, 0);
        chk("R11 status", {27'd0, raw_status}, 0);
        chk("R11 clk", {16'd0, clk_cfg_active}, 0);

        // R3 clock update
        clk_cfg_pend = 16'hA5C3;
        cmd_we = 1; cmd_wdata = 32'h8000_0200;
        @(negedge clk);
        cmd_we = 0;
        chk("R3 start set", {31'd0, start_bit}, 1);
        chk("R3 no valid", {31'd0, ciu_valid}, 0);
        chk("R3 clk old", {16'd0, clk_cfg_active}, 0);
        @(negedge clk);
        chk("R3 start clear", {31'd0, start_bit}, 0);
        chk("R3 clk new", {16'd0, clk_cfg_active}, 32'hA5C3);

        // R4 lock error, R10 argument freeze, R9 controller reset
        issue(32'h8000_0411, 32'h1111_2222);
        cmd_we = 1; cmd_wdata = 32'h8000_0033;
        @(negedge clk);
        cmd_we = 0;
        chk("R4 hle", {31'd0, raw_status[4]}, 1);
        chk("R4 cmd kept", ciu_cmd, 32'h8000_0411);
        arg_we = 1; arg_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        arg_we = 0;
        chk("R10 arg kept", ciu_arg, 32'h1111_2222);
        ctl_rst_we = 1;
        @(negedge clk);
        ctl_rst_we = 0;
        chk("R9 rstbit set", {31'd0, ctl_rst_bit}, 1);
        chk("R9 valid low", {31'd0, ciu_valid}, 0);
        @(negedge clk);
        chk("R9 rstbit clear", {31'd0, ctl_rst_bit}, 0);
        chk("R9 start dropped", {31'd0, start_bit}, 0);
        chk("R9 status kept", {31'd0, raw_status[4]}, 1);

        // R8 set and clear in the same cycle
        issue(32'h8000_0005, 32'h0);
        cmd_we = 1; cmd_wdata = 32'h8000_0006;
        sts_clr_we = 1; sts_clr_mask = 5'h10;
        @(negedge clk);
        cmd_we = 0; sts_clr_we = 0;
        chk("R8 set wins", {31'd0, raw_status[4]}, 1);
        ctl_rst_we = 1;
        @(negedge clk);
        ctl_rst_we = 0;
        @(negedge clk);
        clear_all();
        chk("R8 clear", {27'd0, raw_status}, 0);

        // R5 wait for card idle
        card_busy = 1; ciu_ready = 1;
        issue(32'h8000_0108, 32'h77);
        repeat (3) begin
            chk("R5 held", {30'd0, ciu_valid, start_bit}, 32'd1);
            @(negedge clk);
        end
        card_busy = 0;
        @(negedge clk);
        ciu_ready = 0;
        chk("R5 accepted", {31'd0, start_bit}, 0);
        resp_seen = 1;
        @(negedge clk);
        resp_seen = 0;
        clear_all();
        card_busy = 1;
        issue(32'h8000_0009, 32'h78);
        chk("R5 busy ignored", {31'd0, ciu_valid}, 1);
        ciu_ready = 1;
        @(negedge clk);
        ciu_ready = 0; card_busy = 0;
        resp_seen = 1;
        @(negedge clk);
        resp_seen = 0;
        clear_all();

        // R6 tie and one past the limit, R7 data limits
        resp_tmo = 3; data_tmo = 2;
        run_cmd(32'h8000_000A, 32'h10, 0, 3, 0);
        run_cmd(32'h8000_000B, 32'h11, 1, 4, 0);
        run_cmd(32'h8000_004C, 32'h12, 0, 1, 2);
        run_cmd(32'h8000_004D, 32'h13, 2, 0, 3);

        // random commands
        for (int i = 0; i < 40; i++) begin
            logic [31:0] w;
            int l, m, d, e, rd;
            l  = $urandom_range(0, 6);
            m  = $urandom_range(0, 8);
            d  = $urandom_range(0, l + 2);
            e  = $urandom_range(0, m + 2);
            rd = $urandom_range(0, 3);
            w  = $urandom;
            w[31] = 1'b1; w[9] = 1'b0; w[30:12] = '0;
            resp_tmo = 8'(l);
            data_tmo = 24'(m);
            run_cmd(w, $urandom, rd, d, e);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule